// File: doc/BRIEF.md
# Cell-Based Source Session Interface

This block sits between a slow data producer and one port of a circuit-switched on-chip network. Words from the producer are collected into fixed-size cells. Only the final cell of a message may hold fewer words. A cell is offered to the network only after it has been stored in full, so once a circuit exists the cell can leave as a back-to-back burst at the network rate.

For every cell the block first sends a two-flit control packet. The first flit carries the target address and a code for the cell's place in the message: first, middle, or last/single. The second flit carries this port's own address. The block then waits for the network's answer. An acknowledge starts the burst, and an end-of-packet sideband on the last data flit releases the circuit. A refusal makes the block stay silent for a back-off period tied to the cell length, and then it requests the same cell again.

Storage is split into two halves, each holding one cell. The producer can fill one half while the other is waiting for a circuit or being sent. The first cell of a message opens a session at the target and the last cell closes it.

Top module: `cell_src_session`

## Requirements
- R1: `gen_ready` is low exactly when both buffer halves hold cells that have not finished sending. A word offered while `gen_ready` is high is accepted, and no accepted word is lost or reordered.
- R2: A cell closes after CELL_FLITS words, or earlier on the word marked `gen_last`. Only the final cell of a message can be shorter than CELL_FLITS.
- R3: A control packet is requested only for a cell that is fully stored. It is two consecutive cycles with `net_valid` and `net_ctrl` high. Flit 0 holds the target in bits [ADDR_W-1:0] and the position code in bits [ADDR_W+1:ADDR_W], with all higher bits zero. Flit 1 holds SRC_ADDR in bits [ADDR_W-1:0], with all higher bits zero.
- R4: The position code is 2'b01 for the first cell of a multi-cell message, 2'b00 for a middle cell, and 2'b10 for the last cell or a single-cell message.
- R5: After the control packet, `net_valid` stays low until a response arrives. An acknowledge sampled while waiting starts the burst in the next cycle. The burst sends the cell's words in order, one per cycle, with `net_ctrl` low and no gaps.
- R6: `net_eop` is high on the final data flit of each cell and on no other cycle.
- R7: A refusal sampled while waiting leaves `net_valid` low for exactly CELL_FLITS*BACKOFF_SCALE cycles. The same control packet for the same cell then follows, and the cell's data is kept.
- R8: The target of a message is taken from `gen_target` on its first word and is used for all of its cells. `gen_target` is ignored on every other word.
- R9: During and right after reset, `net_valid`, `net_ctrl` and `net_eop` are low and `gen_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_valid | input | 1 | Producer offers a word |
| gen_data | input | FLIT_W | Producer word |
| gen_last | input | 1 | Word is the last of its message |
| gen_target | input | ADDR_W | Target address, used on a message's first word |
| gen_ready | output | 1 | Block can take a word this cycle |
| net_valid | output | 1 | A flit is on `net_data` |
| net_ctrl | output | 1 | Current flit belongs to a control packet |
| net_data | output | FLIT_W | Outgoing flit |
| net_eop | output | 1 | Last data flit of a cell |
| net_ack | input | 1 | Circuit granted (one-cycle pulse) |
| net_nack | input | 1 | Circuit or session refused (one-cycle pulse) |

## Verification
The bench builds the block with CELL_FLITS=4 and BACKOFF_SCALE=2, which gives an 8-cycle back-off. With cells this short, messages of 1 to 13 words produce single cells, exact multiples of the cell size, and short final cells. First, middle and last codes all appear many times. Long response delays from the bench's network model let both halves fill up, so the stall on `gen_ready` shows up. Repeated refusals of the same cell are also within reach.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ0    = 3'd1,
    ST_REQ1    = 3'd2,
    ST_WAIT    = 3'd3,
    ST_BURST   = 3'd4,
    ST_BACKOFF = 3'd5
  } tx_state_t;

  // Cell position codes carried in control flit 0
  localparam logic [1:0] POS_MID   = 2'b00;
  localparam logic [1:0] POS_FIRST = 2'b01;
  localparam logic [1:0] POS_LAST  = 2'b10;

endpackage

// File: rtl/cell_pair_buffer.sv
`timescale 1ns/1ps
module cell_pair_buffer
  import cs_pkg::*;
#(
  parameter int FLIT_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int CELL_FLITS = 16,
  localparam int IDX_W     = (CELL_FLITS > 1) ? $clog2(CELL_FLITS) : 1,
  localparam int LEN_W     = $clog2(CELL_FLITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLIT_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] wr_tgt,
  output logic              wr_ready,
  input  logic              rd_release,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_full,
  output logic [LEN_W-1:0]  rd_len,
  output logic [1:0]        rd_pos,
  output logic [ADDR_W-1:0] rd_tgt,
  output logic [FLIT_W-1:0] rd_data
);

  // writer state
  logic              wr_half_q, wr_half_d;
  logic [LEN_W-1:0]  wr_cnt_q, wr_cnt_d;
  logic              started_q, started_d;
  logic [ADDR_W-1:0] cell_tgt_q, cell_tgt_d;
  // reader state
  logic              rd_half_q, rd_half_d;

  logic              close;
  logic [1:0]        close_pos;
  logic [ADDR_W-1:0] close_tgt;
  logic [LEN_W-1:0]  close_len;
  logic              first_word;

  logic              half_full [2];
  logic [LEN_W-1:0]  half_len  [2];
  logic [1:0]        half_pos  [2];
  logic [ADDR_W-1:0] half_tgt  [2];
  logic [FLIT_W-1:0] half_data [2];

  always_comb begin
    first_word = (wr_cnt_q == '0) && !started_q;
    close      = wr_en && ((wr_cnt_q == LEN_W'(CELL_FLITS - 1)) || wr_last);
    close_len  = wr_cnt_q + 1'b1;
    close_tgt  = first_word ? wr_tgt : cell_tgt_q;
    if (wr_last)        close_pos = POS_LAST;
    else if (started_q) close_pos = POS_MID;
    else                close_pos = POS_FIRST;
  end

  always_comb begin
    wr_cnt_d   = wr_cnt_q;
    wr_half_d  = wr_half_q;
    started_d  = started_q;
    cell_tgt_d = cell_tgt_q;
    rd_half_d  = rd_half_q;
    if (wr_en && first_word) cell_tgt_d = wr_tgt;
    if (close) begin
      wr_cnt_d  = '0;
      wr_half_d = ~wr_half_q;
      started_d = !wr_last;
    end else if (wr_en) begin
      wr_cnt_d  = wr_cnt_q + 1'b1;
    end
    if (rd_release) rd_half_d = ~rd_half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_half_q  <= 1'b0;
      wr_cnt_q   <= '0;
      started_q  <= 1'b0;
      cell_tgt_q <= '0;
      rd_half_q  <= 1'b0;
    end else begin
      wr_half_q  <= wr_half_d;
      wr_cnt_q   <= wr_cnt_d;
      started_q  <= started_d;
      cell_tgt_q <= cell_tgt_d;
      rd_half_q  <= rd_half_d;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [FLIT_W-1:0] mem [CELL_FLITS];
    logic              full_q, full_d;
    logic [LEN_W-1:0]  len_q, len_d;
    logic [1:0]        pos_q, pos_d;
    logic [ADDR_W-1:0] tgt_q, tgt_d;
    logic              sel_wr, sel_close, sel_rel;

    always_comb begin
      sel_wr    = wr_en && (wr_half_q == 1'(h));
      sel_close = close && (wr_half_q == 1'(h));
      sel_rel   = rd_release && (rd_half_q == 1'(h));
      full_d    = full_q;
      len_d     = len_q;
      pos_d     = pos_q;
      tgt_d     = tgt_q;
      if (sel_close) begin
        full_d = 1'b1;
        len_d  = close_len;
        pos_d  = close_pos;
        tgt_d  = close_tgt;
      end else if (sel_rel) begin
        full_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        len_q  <= '0;
        pos_q  <= POS_MID;
        tgt_q  <= '0;
      end else begin
        full_q <= full_d;
        len_q  <= len_d;
        pos_q  <= pos_d;
        tgt_q  <= tgt_d;
      end
    end

    // data storage: write-enabled, no reset
    always_ff @(posedge clk) begin
      if (sel_wr) mem[wr_cnt_q[IDX_W-1:0]] <= wr_data;
    end

    always_comb begin
      half_full[h] = full_q;
      half_len[h]  = len_q;
      half_pos[h]  = pos_q;
      half_tgt[h]  = tgt_q;
      half_data[h] = mem[rd_idx];
    end
  end

  always_comb begin
    wr_ready = !half_full[wr_half_q];
    rd_full  = half_full[rd_half_q];
    rd_len   = half_len[rd_half_q];
    rd_pos   = half_pos[rd_half_q];
    rd_tgt   = half_tgt[rd_half_q];
    rd_data  = half_data[rd_half_q];
  end

endmodule

// File: rtl/cell_tx_ctrl.sv
`timescale 1ns/1ps
module cell_tx_ctrl
  import cs_pkg::*;
#(
  parameter int CELL_FLITS    = 16,
  parameter int BACKOFF_SCALE = 1,
  localparam int IDX_W        = (CELL_FLITS > 1) ? $clog2(CELL_FLITS) : 1,
  localparam int LEN_W        = $clog2(CELL_FLITS + 1),
  localparam int BACKOFF_CYC  = CELL_FLITS * BACKOFF_SCALE,
  localparam int BO_W         = $clog2(BACKOFF_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_ready,
  input  logic [LEN_W-1:0] cell_len,
  input  logic             net_ack,
  input  logic             net_nack,
  output tx_state_t        state,
  output logic [IDX_W-1:0] flit_idx,
  output logic             last_flit,
  output logic             release_cell
);

  tx_state_t        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [BO_W-1:0]  bo_q, bo_d;

  always_comb begin
    last_flit    = (state_q == ST_BURST) && ((int'(idx_q) + 1) == int'(cell_len));
    release_cell = last_flit;
    state        = state_q;
    flit_idx     = idx_q;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bo_d    = bo_q;
    case (state_q)
      ST_IDLE:  if (cell_ready) state_d = ST_REQ0;
      ST_REQ0:  state_d = ST_REQ1;
      ST_REQ1:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (net_ack) begin
          state_d = ST_BURST;
          idx_d   = '0;
        end else if (net_nack) begin
          state_d = ST_BACKOFF;
          bo_d    = '0;
        end
      end
      ST_BURST: begin
        if (last_flit) state_d = ST_IDLE;
        else           idx_d   = idx_q + 1'b1;
      end
      ST_BACKOFF: begin
        if (bo_q == BO_W'(BACKOFF_CYC - 1)) state_d = ST_REQ0;
        else                                bo_d    = bo_q + 1'b1;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      bo_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bo_q    <= bo_d;
    end
  end

endmodule

// File: rtl/cell_flit_mux.sv
`timescale 1ns/1ps
module cell_flit_mux
  import cs_pkg::*;
#(
  parameter int FLIT_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] SRC_ADDR = '0
) (
  input  tx_state_t         state,
  input  logic [1:0]        cell_pos,
  input  logic [ADDR_W-1:0] cell_tgt,
  input  logic [FLIT_W-1:0] cell_data,
  input  logic              last_flit,
  output logic              net_valid,
  output logic              net_ctrl,
  output logic [FLIT_W-1:0] net_data,
  output logic              net_eop
);

  logic [FLIT_W-1:0] head0, head1;

  always_comb begin
    head0 = '0;
    head0[ADDR_W-1:0]      = cell_tgt;
    head0[ADDR_W+1:ADDR_W] = cell_pos;
    head1 = '0;
    head1[ADDR_W-1:0]      = SRC_ADDR;
  end

  always_comb begin
    net_valid = 1'b0;
    net_ctrl  = 1'b0;
    net_data  = '0;
    net_eop   = 1'b0;
    case (state)
      ST_REQ0: begin
        net_valid = 1'b1;
        net_ctrl  = 1'b1;
        net_data  = head0;
      end
      ST_REQ1: begin
        net_valid = 1'b1;
        net_ctrl  = 1'b1;
        net_data  = head1;
      end
      ST_BURST: begin
        net_valid = 1'b1;
        net_data  = cell_data;
        net_eop   = last_flit;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cell_src_session.sv
`timescale 1ns/1ps
module cell_src_session
  import cs_pkg::*;
#(
  parameter int FLIT_W        = 8,
  parameter int ADDR_W        = 5,
  parameter int CELL_FLITS    = 16,
  parameter int BACKOFF_SCALE = 1,
  parameter logic [ADDR_W-1:0] SRC_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_valid,
  input  logic [FLIT_W-1:0] gen_data,
  input  logic              gen_last,
  input  logic [ADDR_W-1:0] gen_target,
  output logic              gen_ready,
  output logic              net_valid,
  output logic              net_ctrl,
  output logic [FLIT_W-1:0] net_data,
  output logic              net_eop,
  input  logic              net_ack,
  input  logic              net_nack
);

  localparam int IDX_W = (CELL_FLITS > 1) ? $clog2(CELL_FLITS) : 1;
  localparam int LEN_W = $clog2(CELL_FLITS + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic              wr_en;
  logic              rd_full;
  logic [LEN_W-1:0]  rd_len;
  logic [1:0]        rd_pos;
  logic [ADDR_W-1:0] rd_tgt;
  logic [FLIT_W-1:0] rd_data;
  logic [IDX_W-1:0]  flit_idx;
  logic              last_flit;
  logic              release_cell;
  tx_state_t         tx_state;

  assign wr_en = gen_valid && gen_ready;

  cell_pair_buffer #(
    .FLIT_W    (FLIT_W),
    .ADDR_W    (ADDR_W),
    .CELL_FLITS(CELL_FLITS)
  ) i_buf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_data   (gen_data),
    .wr_last   (gen_last),
    .wr_tgt    (gen_target),
    .wr_ready  (gen_ready),
    .rd_release(release_cell),
    .rd_idx    (flit_idx),
    .rd_full   (rd_full),
    .rd_len    (rd_len),
    .rd_pos    (rd_pos),
    .rd_tgt    (rd_tgt),
    .rd_data   (rd_data)
  );

  cell_tx_ctrl #(
    .CELL_FLITS   (CELL_FLITS),
    .BACKOFF_SCALE(BACKOFF_SCALE)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cell_ready  (rd_full),
    .cell_len    (rd_len),
    .net_ack     (net_ack),
    .net_nack    (net_nack),
    .state       (tx_state),
    .flit_idx    (flit_idx),
    .last_flit   (last_flit),
    .release_cell(release_cell)
  );

  cell_flit_mux #(
    .FLIT_W  (FLIT_W),
    .ADDR_W  (ADDR_W),
    .SRC_ADDR(SRC_ADDR)
  ) i_mux (
    .state    (tx_state),
    .cell_pos (rd_pos),
    .cell_tgt (rd_tgt),
    .cell_data(rd_data),
    .last_flit(last_flit),
    .net_valid(net_valid),
    .net_ctrl (net_ctrl),
    .net_data (net_data),
    .net_eop  (net_eop)
  );

endmodule

// File: rtl/cell_src_session_chk.sv
`timescale 1ns/1ps
module cell_src_session_chk
  import cs_pkg::*;
#(
  parameter int FLIT_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] SRC_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              net_valid,
  input logic              net_ctrl,
  input logic [FLIT_W-1:0] net_data,
  input logic              net_eop,
  input logic              net_ack,
  input logic              net_nack,
  input tx_state_t         st
);

  p_eop_data_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    net_eop |-> (net_valid && !net_ctrl));

  p_ctl_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (net_ctrl && !$past(net_ctrl)) |=> net_ctrl);

  p_src_flit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (net_ctrl && $past(net_ctrl)) |-> (net_data[ADDR_W-1:0] == SRC_ADDR));

  p_pos_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (net_ctrl && !$past(net_ctrl)) |-> (net_data[ADDR_W+1:ADDR_W] != 2'b11));

  p_quiet_after_ctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (net_ctrl && $past(net_ctrl)) |=> !net_valid);

  p_ack_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && net_ack) |=> (net_valid && !net_ctrl));

  p_burst_gapless_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && !net_ctrl && !net_eop) |=> (net_valid && !net_ctrl));

  p_nack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && net_nack && !net_ack) |=> !net_valid);

endmodule

bind cell_src_session cell_src_session_chk #(
  .FLIT_W  (FLIT_W),
  .ADDR_W  (ADDR_W),
  .SRC_ADDR(SRC_ADDR)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .net_valid(net_valid),
  .net_ctrl (net_ctrl),
  .net_data (net_data),
  .net_eop  (net_eop),
  .net_ack  (net_ack),
  .net_nack (net_nack),
  .st       (tx_state)
);

// File: tb/test_cell_src_session.sv
`timescale 1ns/1ps
module test_cell_src_session;

  localparam int FW  = 8;
  localparam int AW  = 5;
  localparam int CF  = 4;
  localparam int BS  = 2;
  localparam int BO  = CF * BS;
  localparam logic [AW-1:0] SRC = 5'h13;
  localparam int MAXW = 4096;
  localparam int MAXC = 2048;

  logic          clk;
  logic          rst_n;
  logic          gen_valid;
  logic [FW-1:0] gen_data;
  logic          gen_last;
  logic [AW-1:0] gen_target;
  logic          gen_ready;
  logic          net_valid;
  logic          net_ctrl;
  logic [FW-1:0] net_data;
  logic          net_eop;
  logic          net_ack;
  logic          net_nack;

  cell_src_session #(
    .FLIT_W(FW), .ADDR_W(AW), .CELL_FLITS(CF), .BACKOFF_SCALE(BS), .SRC_ADDR(SRC)
  ) i_cell_src_session (
    .clk(clk), .rst_n(rst_n),
    .gen_valid(gen_valid), .gen_data(gen_data), .gen_last(gen_last),
    .gen_target(gen_target), .gen_ready(gen_ready),
    .net_valid(net_valid), .net_ctrl(net_ctrl), .net_data(net_data),
    .net_eop(net_eop), .net_ack(net_ack), .net_nack(net_nack)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected stream, computed from the requirements
  logic [FW-1:0] w_data  [MAXW];
  logic          w_last  [MAXW];
  logic          w_close [MAXW];
  logic [AW-1:0] w_tgt   [MAXW];
  int            c_start [MAXC];
  int            c_len   [MAXC];
  logic [1:0]    c_pos   [MAXC];
  logic [AW-1:0] c_tgt   [MAXC];
  int n_words, n_cells;
  int vectors, fails;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 R4 R8: split a message into cells; non-first words carry a junk target
  task automatic add_msg(input int len, input logic [AW-1:0] tgt);
    for (int i = 0; i < len; i++) begin
      w_data[n_words]  = FW'($urandom);
      w_last[n_words]  = (i == len - 1);
      w_close[n_words] = ((i % CF) == CF - 1) || (i == len - 1);
      w_tgt[n_words]   = (i == 0) ? tgt : AW'($urandom);
      if ((i % CF) == 0) begin
        c_start[n_cells] = n_words;
        c_tgt[n_cells]   = tgt;
        c_len[n_cells]   = (len - i < CF) ? (len - i) : CF;
        if (i + CF >= len) c_pos[n_cells] = 2'b10;
        else if (i == 0)   c_pos[n_cells] = 2'b01;
        else               c_pos[n_cells] = 2'b00;
        n_cells++;
      end
      n_words++;
    end
  endtask

  int wi, cell_rd, closed, released, nst, wait_left, bidx, bo_count, attempts;
  bit in_backoff, done;
  logic [FW-1:0] exp0;

  initial begin
    vectors = 0; fails = 0; n_words = 0; n_cells = 0;
    wi = 0; cell_rd = 0; closed = 0; released = 0; nst = 0;
    wait_left = 0; bidx = 0; bo_count = 0; attempts = 0;
    in_backoff = 1'b0; done = 1'b0;
    void'($urandom(32'd20240611));
    gen_valid = 1'b0; gen_data = '0; gen_last = 1'b0; gen_target = '0;
    net_ack = 1'b0; net_nack = 1'b0;
    rst_n = 1'b0;

    // directed lengths: single word, exact cell, cell+1, two cells, short, three cells
    add_msg(1, 5'h01);
    add_msg(CF, 5'h02);
    add_msg(CF + 1, 5'h1F);
    add_msg(2 * CF, 5'h04);
    add_msg(3, 5'h05);
    add_msg(3 * CF, 5'h0A);
    for (int m = 0; m < 40; m++) add_msg(1 + int'($urandom % 13), AW'($urandom));

    repeat (3) @(negedge clk);
    check(!net_valid && !net_ctrl && !net_eop, "R9 outputs in reset", int'(net_valid), 0);
    check(gen_ready == 1'b1, "R9 ready in reset", int'(gen_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!net_valid && !net_eop, "R9 outputs after reset", int'(net_valid), 0);

    for (int cyc = 0; cyc < 150000 && !done; cyc++) begin
      @(negedge clk);
      net_ack  = 1'b0;
      net_nack = 1'b0;
      gen_valid = 1'b0;

      // R1: stall exactly when both halves are occupied
      check(gen_ready == ((closed - released) < 2), "R1 ready", int'(gen_ready),
            int'((closed - released) < 2));

      case (nst)
        0: begin
          if (net_valid) begin
            check(net_ctrl == 1'b1, "R3 ctrl on flit0", int'(net_ctrl), 1);
            check(cell_rd < closed, "R3 cell stored before request", cell_rd, closed);
            exp0 = '0;
            exp0[AW-1:0]  = c_tgt[cell_rd];
            exp0[AW+1:AW] = c_pos[cell_rd];
            check(net_data == exp0, "R4 R8 flit0", int'(net_data), int'(exp0));
            if (in_backoff)
              check(bo_count == BO, "R7 back-off length", bo_count, BO);
            in_backoff = 1'b0;
            nst = 1;
          end else if (in_backoff) begin
            bo_count++;
          end
          check(!net_eop, "R6 no eop idle", int'(net_eop), 0);
        end
        1: begin
          check(net_valid && net_ctrl && (net_data == FW'(SRC)), "R3 flit1",
                int'(net_data), int'(SRC));
          wait_left = (($urandom % 6) == 0) ? 25 : int'($urandom % 4);
          nst = 2;
        end
        2: begin
          check(!net_valid, "R5 quiet while waiting", int'(net_valid), 0);
          if (wait_left == 0) begin
            bit refuse;
            if (cell_rd == 0)      refuse = (attempts < 2);
            else if (cell_rd == 3) refuse = (attempts == 0);
            else                   refuse = (attempts < 3) && (($urandom % 4) == 0);
            attempts++;
            if (refuse) begin
              net_nack   = 1'b1;
              in_backoff = 1'b1;
              bo_count   = 0;
              nst        = 0;
            end else begin
              net_ack = 1'b1;
              bidx    = 0;
              nst     = 3;
            end
          end else begin
            wait_left--;
          end
        end
        default: begin
          check(net_valid && !net_ctrl, "R5 burst flit present", int'(net_valid), 1);
          check(net_data == w_data[c_start[cell_rd] + bidx], "R5 R7 burst data",
                int'(net_data), int'(w_data[c_start[cell_rd] + bidx]));
          check(net_eop == (bidx == c_len[cell_rd] - 1), "R2 R6 eop position",
                int'(net_eop), int'(bidx == c_len[cell_rd] - 1));
          if (bidx == c_len[cell_rd] - 1) begin
            cell_rd++;
            released++;
            attempts = 0;
            nst = 0;
          end else begin
            bidx++;
          end
        end
      endcase

      // producer: offers a word only while ready is seen
      if (gen_ready && (wi < n_words) && (($urandom % 8) < 5)) begin
        gen_valid  = 1'b1;
        gen_data   = w_data[wi];
        gen_last   = w_last[wi];
        gen_target = w_tgt[wi];
        if (w_close[wi]) closed++;
        wi++;
      end

      done = (cell_rd == n_cells) && (wi == n_words);
    end

    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL R5 watchdog: cells sent=%0d expected=%0d", cell_rd, n_cells);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule